// File: doc/BRIEF.md
# Highest-Request BCD Encoder

This block watches a bank of sixteen request lines, numbered 1 through 16. Bit i of the request bus stands for request number i+1. The block picks the highest-numbered line that is active and reports that number as two packed BCD digits. The tens digit sits in bits 7:4 and the units digit in bits 3:0.

A separate one-bit flag says whether any line is active at all. When nothing is active, both the digits and the flag read zero. Request lines are active-high; any polarity correction belongs to the logic that feeds this block.

The result can pass through one output register so that readers see clean, edge-aligned values. A parameter can remove the register, which makes the block purely combinational.

Top module: `prienc_bcd16`

## Requirements
- R1: The reported number is one plus the bit position of the highest set bit of `reqIn`.
- R2: `bcdOut[7:4]` holds the tens digit and `bcdOut[3:0]` the units digit. With bits 4 and 15 set (requests 5 and 16), `bcdOut` is 8'h16. With only bit 8 set, it is 8'h09.
- R3: When `reqIn` is all zeros, `bcdOut` is 8'h00.
- R4: `anyActive` is 1 when at least one request bit is set and 0 otherwise.
- R5: The units digit never exceeds 9 and the tens digit never exceeds 1.
- R6: With the output register present (`OUT_REG` = 1), the following hold:
  - While `rstN` is low, `bcdOut` is 0 and `anyActive` is 0.
  - After a request change, the outputs update at the next rising edge of `clk` and not before.
- R7: Request bits below the winning bit have no effect on the outputs. With bits 0 and 9 set, `bcdOut` is 8'h10, the same as with bit 9 alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| reqIn | input | NUM_REQ | Request lines; bit i is request number i+1 |
| bcdOut | output | 8 | Winning request number as tens:units BCD |
| anyActive | output | 1 | High when any request line is set |

## Verification
The bench builds the block with `NUM_REQ` = 16 and `OUT_REG` = 1. At that size, all 65536 request patterns can be applied, one per clock. This covers every single-line, multi-line and empty pattern, each compared against an arithmetic top-down scan with a divide-by-ten split. With the register enabled, the reset value and the one-edge update timing can also be observed at the ports.

// File: rtl/prienc_pkg.sv
`timescale 1ns/1ps
package prienc_pkg;
  // Largest request count supported by the number field (fits two BCD digits)
  localparam int REQ_COUNT = 16;
  localparam int NUM_W     = 5;
  localparam int DIGIT_W   = 4;
  localparam int DIGITS    = 2;
  localparam int BCD_W     = DIGIT_W * DIGITS;

  // Strobes handed from the scan control to the conversion datapath
  typedef struct packed {
    logic             hit;     // some request is active
    logic [NUM_W-1:0] number;  // one-based number of the winner, 0 if none
  } scanStrobe_t;
endpackage

// File: rtl/prienc_scan.sv
`timescale 1ns/1ps
module prienc_scan
  import prienc_pkg::*;
#(
  parameter int NUM_REQ = REQ_COUNT
) (
  input  logic [NUM_REQ-1:0] reqIn,
  output scanStrobe_t        strobe
);
  // Ascending walk: each later (higher) active bit overrides earlier ones,
  // so the highest-numbered request is left standing.
  always_comb begin
    strobe.hit    = 1'b0;
    strobe.number = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (reqIn[i]) begin
        strobe.hit    = 1'b1;
        strobe.number = NUM_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/prienc_bcd_path.sv
`timescale 1ns/1ps
module prienc_bcd_path
  import prienc_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  scanStrobe_t      strobe,
  output logic [BCD_W-1:0] bcdOut,
  output logic             anyActive
);
  // Shift-and-add-3 conversion of the binary number into BCD digits
  function automatic logic [BCD_W-1:0] toBcd(input logic [NUM_W-1:0] bin);
    logic [BCD_W-1:0] acc;
    acc = '0;
    for (int b = NUM_W - 1; b >= 0; b--) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (acc[d*DIGIT_W +: DIGIT_W] >= DIGIT_W'(5))
          acc[d*DIGIT_W +: DIGIT_W] = acc[d*DIGIT_W +: DIGIT_W] + DIGIT_W'(3);
      end
      acc = {acc[BCD_W-2:0], bin[b]};
    end
    return acc;
  endfunction

  logic [BCD_W-1:0] bcdNext;
  assign bcdNext = toBcd(strobe.number);

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bcdOut    <= '0;
          anyActive <= 1'b0;
        end else begin
          bcdOut    <= bcdNext;
          anyActive <= strobe.hit;
        end
      end
    end else begin : g_comb
      assign bcdOut    = bcdNext;
      assign anyActive = strobe.hit;
    end
  endgenerate
endmodule

// File: rtl/prienc_bcd16.sv
`timescale 1ns/1ps
module prienc_bcd16
  import prienc_pkg::*;
#(
  parameter int NUM_REQ = REQ_COUNT,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqIn,
  output logic [BCD_W-1:0]   bcdOut,
  output logic               anyActive
);
  scanStrobe_t strobe;

  prienc_scan #(.NUM_REQ(NUM_REQ)) u_scan (
    .reqIn  (reqIn),
    .strobe (strobe)
  );

  prienc_bcd_path #(.OUT_REG(OUT_REG)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .bcdOut    (bcdOut),
    .anyActive (anyActive)
  );
endmodule

// File: rtl/prienc_bcd16_checker.sv
`timescale 1ns/1ps
module prienc_bcd16_checker #(
  parameter int NUM_REQ = 16,
  parameter bit OUT_REG = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_REQ-1:0] reqIn,
  input logic [7:0]         bcdOut,
  input logic               anyActive
);
  // Set once a full clock has passed out of reset, so $past is meaningful
  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  assert_digit_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (bcdOut[3:0] <= 4'd9) && (bcdOut[7:4] <= 4'd1));

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    !anyActive |-> (bcdOut == 8'h00));

  assert_active_nonzero_R4: assert property (@(posedge clk) disable iff (!rstN)
    anyActive |-> (bcdOut != 8'h00));

  generate
    if (OUT_REG) begin : g_seq
      assert_reset_clear_R6: assert property (@(posedge clk)
        !rstN |-> (bcdOut == 8'h00) && !anyActive);

      assert_flag_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
        pastOk |-> (anyActive == $past(|reqIn)));

      assert_top_wins_R1: assert property (@(posedge clk) disable iff (!rstN)
        pastOk && $past(reqIn[NUM_REQ-1]) |-> (bcdOut == 8'h16));

      assert_tens_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
        pastOk && ($past(reqIn[NUM_REQ-1:9]) == '0) |-> (bcdOut[7:4] == 4'd0));
    end
  endgenerate
endmodule

bind prienc_bcd16 prienc_bcd16_checker #(.NUM_REQ(NUM_REQ), .OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqIn     (reqIn),
  .bcdOut    (bcdOut),
  .anyActive (anyActive)
);

// File: tb/prienc_bcd16_bench.sv
`timescale 1ns/1ps
module prienc_bcd16_bench;
  logic        clk  = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] req  = '0;
  logic [7:0]  bcdOut;
  logic        anyActive;
  int          vectors = 0;
  int          miscompares = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  prienc_bcd16 #(.NUM_REQ(16), .OUT_REG(1'b1)) u_prienc_bcd16 (
    .clk       (clk),
    .rstN      (rstN),
    .reqIn     (req),
    .bcdOut    (bcdOut),
    .anyActive (anyActive)
  );

  // Reference: scan down from the top bit, then split by ten
  function automatic logic [7:0] refBcd(input logic [15:0] r);
    int n;
    n = 0;
    for (int i = 15; i >= 0; i--) begin
      if (r[i] && n == 0) n = i + 1;
    end
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  task automatic check(input string tag, input logic [7:0] expB, input logic expA);
    vectors++;
    if (bcdOut !== expB || anyActive !== expA) begin
      miscompares++;
      $display("FAIL %s: req=%h bcd=%h active=%b expected bcd=%h active=%b",
               tag, req, bcdOut, anyActive, expB, expA);
    end
  endtask

  task automatic apply(input logic [15:0] v);
    req = v;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    req = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R6 outputs held clear in reset", 8'h00, 1'b0);
    rstN = 1'b1;
    #1;
    check("R6 no update before the edge", 8'h00, 1'b0);
    @(negedge clk);
    check("R6 update after one edge", 8'h16, 1'b1);

    apply(16'h8010);
    check("R2 requests 5 and 16", 8'h16, 1'b1);
    apply(16'h0100);
    check("R2 request 9 alone", 8'h09, 1'b1);
    apply(16'h0000);
    check("R3 no request", 8'h00, 1'b0);
    apply(16'h0201);
    check("R7 requests 1 and 10", 8'h10, 1'b1);
    apply(16'h0200);
    check("R7 lower bit removed", 8'h10, 1'b1);
    apply(16'h7FFF);
    check("R1 fifteen lowest set", 8'h15, 1'b1);

    for (int v = 0; v < 65536; v++) begin
      apply(16'(v));
      check("R1/R4 sweep", refBcd(req), |req);
      vectors++;
      if (bcdOut[7:4] > 4'd1 || bcdOut[3:0] > 4'd9) begin
        miscompares++;
        $display("FAIL R5: req=%h bcd=%h expected digits tens<=1 units<=9",
                 req, bcdOut);
      end
    end

    done = 1'b1;
    summary();
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R1: run hung, actual=timeout expected=completion");
      summary();
    end
  end
endmodule